// File: doc/BRIEF.md
# Parallel FPGA Configuration Master

This block loads a configuration bitstream into an FPGA over an 8-bit slave-parallel port. A host first issues a reset command. The block then holds the FPGA in reset for a programmable number of clock ticks while it drives the chosen mode-pin pattern. After releasing reset it waits for the FPGA's initialisation-ready input (INIT_B) and records an initial status code.

Bitstream bytes then arrive on a valid/ready byte stream, grouped into chunks. A chunk-end marker closes each chunk. Each accepted byte is placed on the data bus and clocked into the FPGA with one configuration-clock pulse. A 32-bit byte count and an 8-bit additive checksum are kept along the way.

The load ends in one of two ways: a chunk shorter than the full chunk size arrives, or the host sends an explicit finish command. The block then runs a fixed flush of clock pulses, deselects the FPGA, gives a few more pulses and releases its outputs. Finally it samples DONE. A failed configuration restarts the reset phase by itself.

Top module: `fpga_pcfg_master`

## Requirements
- R1: On command code 0 (host-driven load) or 1 (self-load from flash), accepted from idle or loading, `fpga_rst_n_o` is low for exactly `RST_TICKS` cycles. During that time `cs_n_o`=1, `rdwr_o`=0 and `out_en_o`=1, and `mode_o` is `MODE_HOST` (default 2'b10) for code 0 and `MODE_FLASH` (default 2'b11) for code 1.
- R2: After reset release, `init_i` is polled once per cycle for at most `POLL_MAX` cycles. The status becomes 200 if it was seen high and 100 on timeout. Loading then starts, with the byte count and checksum cleared.
- R3: Each accepted byte appears on `data_o` at least one cycle before `cclk_o` rises. `cclk_o` is high for exactly one cycle, and `s_ready_o` is low while a pulse is in progress.
- R4: `checksum_o` is the sum modulo 256 of all bytes accepted since loading started.
- R5: `byte_cnt_o` counts all bytes accepted since loading started.
- R6: A chunk whose length, including the byte marked by `s_last_i`, is below `SHORT_LEN` (default 64) starts the finish sequence after its last pulse. A chunk of exactly `SHORT_LEN` bytes does not.
- R7: When the finish sequence starts, 22 is added to the status if `init_i` is high and 11 if it is low.
- R8: The finish sequence gives `FLUSH_PULSES` (64) clock pulses with `cs_n_o` low. It then raises `cs_n_o` and gives `TAIL_PULSES` (4) more. After that it drops `out_en_o`.
- R9: With `out_en_o` low, `done_i` is sampled once. When it is high, `unconf_o` becomes 0 and the block goes idle. When it is low, `unconf_o` becomes 1 and the reset phase restarts with `MODE_HOST`.
- R10: Command code 2 (finish) is accepted only while loading with no pulse pending. Code 3 is never accepted. A command that is not accepted gives no `cmd_ack_o` and changes no output.
- R11: After reset `out_en_o`=0, `unconf_o`=1, the status is 0, the count is 0 and `s_ready_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req_i | input | 1 | Host command request |
| cmd_op_i | input | 2 | Command code: 0 host reset, 1 flash reset, 2 finish |
| cmd_ack_o | output | 1 | Command accepted this cycle |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Byte closes the chunk |
| s_ready_o | output | 1 | Stream ready |
| fpga_rst_n_o | output | 1 | FPGA reset, active low |
| mode_o | output | 2 | FPGA mode pins |
| cs_n_o | output | 1 | FPGA chip select, active low |
| rdwr_o | output | 1 | Direction line, 0 = write |
| cclk_o | output | 1 | Configuration clock |
| data_o | output | 8 | Configuration data bus |
| out_en_o | output | 1 | Output enable for configuration pins |
| init_i | input | 1 | FPGA INIT_B level |
| done_i | input | 1 | FPGA DONE level |
| status_o | output | 8 | Composite status code |
| unconf_o | output | 1 | 1 = not configured |
| byte_cnt_o | output | CNT_W | Transferred byte count |
| checksum_o | output | 8 | Additive checksum |
| busy_o | output | 1 | Reset, poll or finish phase active |
| loading_o | output | 1 | Loading phase active |

## Verification
Several rules are checked by assertions on every cycle:
- the exact reset-low length;
- the single-cycle clock pulse and data setup before its rising edge;
- stream ready being low during a pulse;
- the per-byte checksum and count steps;
- chip select being high before the outputs are released;
- the restart after an unconfigured result.

Other behaviour needs the bench's scenarios to show it:
- the composite status values 222, 111, 200 and 100;
- the exact flush and tail pulse counts;
- short-chunk detection at the 63/64 boundary;
- ignored commands;
- end-to-end checksum wrap over all 256 byte values.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_POLL,
    ST_LOAD,
    ST_FIN,
    ST_FLUSH,
    ST_TAIL,
    ST_SAMPLE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH
  } pulse_ph_e;

  typedef enum logic [1:0] {
    OP_RST_HOST  = 2'd0,
    OP_RST_FLASH = 2'd1,
    OP_FINISH    = 2'd2,
    OP_NONE      = 2'd3
  } host_op_e;

  localparam logic [7:0] STAT_INIT_HI  = 8'd200;
  localparam logic [7:0] STAT_INIT_TMO = 8'd100;
  localparam logic [7:0] STAT_FIN_HI   = 8'd22;
  localparam logic [7:0] STAT_FIN_LO   = 8'd11;

endpackage

// File: rtl/pcfg_pulser.sv
module pcfg_pulser
  import pcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic cclk_o,
  output logic done_o
);

  pulse_ph_e ph_q, ph_d;
  logic      cclk_q, cclk_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE:  if (start_i) ph_d = PH_SETUP;
      PH_SETUP: ph_d = PH_HIGH;
      PH_HIGH:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
    cclk_d = (ph_d == PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cclk_q <= cclk_d;
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = (ph_q == PH_HIGH);
  assign cclk_o = cclk_q;

  assert_cclk_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |=> !cclk_o);

  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

endmodule

// File: rtl/pcfg_accum.sv
module pcfg_accum #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned SUM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [SUM_W-1:0] byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SUM_W-1:0] sum_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum_q, sum_d;
  logic             en;

  assign en = clr_i | add_i;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
      sum_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      sum_d = sum_q + byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sum_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      sum_q <= sum_d;
    end
  end

  assign cnt_o = cnt_q;
  assign sum_o = sum_q;

  assert_clr_add_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_i && add_i));

endmodule

// File: rtl/pcfg_chunk.sv
module pcfg_chunk #(
  parameter int unsigned SHORT_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic acc_i,
  input  logic last_i,
  output logic short_o
);

  localparam int unsigned LEN_W = $clog2(SHORT_LEN + 1);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(SHORT_LEN);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(SHORT_LEN - 1);

  logic [LEN_W-1:0] len_q, len_d;
  logic             en;

  assign en = clr_i | acc_i;

  always_comb begin
    if (clr_i || last_i) begin
      len_d = '0;
    end else if (len_q != LEN_SAT) begin
      len_d = len_q + LEN_W'(1);
    end else begin
      len_d = len_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (en) begin
      len_q <= len_d;
    end
  end

  assign short_o = acc_i && last_i && (len_q < LEN_LIM);

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_SAT);

endmodule

// File: rtl/fpga_pcfg_master.sv
module fpga_pcfg_master
  import pcfg_pkg::*;
#(
  parameter int unsigned RST_TICKS    = 1000000,
  parameter int unsigned POLL_MAX     = 65535,
  parameter int unsigned SHORT_LEN    = 64,
  parameter int unsigned FLUSH_PULSES = 64,
  parameter int unsigned TAIL_PULSES  = 4,
  parameter int unsigned CNT_W        = 32,
  parameter logic [1:0]  MODE_HOST    = 2'b10,
  parameter logic [1:0]  MODE_FLASH   = 2'b11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_req_i,
  input  logic [1:0]       cmd_op_i,
  output logic             cmd_ack_o,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic             fpga_rst_n_o,
  output logic [1:0]       mode_o,
  output logic             cs_n_o,
  output logic             rdwr_o,
  output logic             cclk_o,
  output logic [7:0]       data_o,
  output logic             out_en_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic [7:0]       status_o,
  output logic             unconf_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic [7:0]       checksum_o,
  output logic             busy_o,
  output logic             loading_o
);

  localparam int unsigned RST_W  = $clog2(RST_TICKS + 1);
  localparam int unsigned POLL_W = $clog2(POLL_MAX + 1);
  localparam int unsigned TMR_W  = (RST_W > POLL_W) ? RST_W : POLL_W;
  localparam int unsigned PMAX   = (FLUSH_PULSES > TAIL_PULSES) ? FLUSH_PULSES : TAIL_PULSES;
  localparam int unsigned PUL_W  = $clog2(PMAX + 1);

  localparam logic [TMR_W-1:0] RST_LAST   = TMR_W'(RST_TICKS - 1);
  localparam logic [TMR_W-1:0] POLL_LAST  = TMR_W'(POLL_MAX - 1);
  localparam logic [PUL_W-1:0] FLUSH_LAST = PUL_W'(FLUSH_PULSES - 1);
  localparam logic [PUL_W-1:0] TAIL_LAST  = PUL_W'(TAIL_PULSES - 1);

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [PUL_W-1:0] pul_q, pul_d;
  logic [1:0]       mode_q, mode_d;
  logic [7:0]       stat_q, stat_d;
  logic             unconf_q, unconf_d;
  logic             pend_q, pend_d;
  logic [7:0]       data_q;

  host_op_e op;
  logic     is_rst_op, is_fin_op;
  logic     load_free, ack, byte_acc, acc_clr;
  logic     pul_start, pul_busy, pul_done, pul_cclk;
  logic     chunk_short;

  assign op        = host_op_e'(cmd_op_i);
  assign is_rst_op = (op == OP_RST_HOST) || (op == OP_RST_FLASH);
  assign is_fin_op = (op == OP_FINISH);
  assign load_free = (state_q == ST_LOAD) && !pul_busy && !pend_q;
  assign ack       = cmd_req_i && ((is_rst_op && ((state_q == ST_IDLE) || load_free)) ||
                                   (is_fin_op && load_free));
  assign s_ready_o = load_free && !ack;
  assign byte_acc  = s_valid_i && s_ready_o;
  assign pul_start = byte_acc ||
                     (((state_q == ST_FLUSH) || (state_q == ST_TAIL)) && !pul_busy);

  pcfg_pulser u_pulser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (pul_start),
    .busy_o  (pul_busy),
    .cclk_o  (pul_cclk),
    .done_o  (pul_done)
  );

  pcfg_accum #(
    .CNT_W (CNT_W),
    .SUM_W (8)
  ) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (acc_clr),
    .add_i  (byte_acc),
    .byte_i (s_data_i),
    .cnt_o  (byte_cnt_o),
    .sum_o  (checksum_o)
  );

  pcfg_chunk #(
    .SHORT_LEN (SHORT_LEN)
  ) u_chunk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (acc_clr),
    .acc_i   (byte_acc),
    .last_i  (s_last_i),
    .short_o (chunk_short)
  );

  // sequencer next state
  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    pul_d    = pul_q;
    mode_d   = mode_q;
    stat_d   = stat_q;
    unconf_d = unconf_q;
    pend_d   = pend_q;
    acc_clr  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ack && is_rst_op) begin
          state_d = ST_RST;
          tmr_d   = '0;
          mode_d  = (op == OP_RST_FLASH) ? MODE_FLASH : MODE_HOST;
        end
      end
      ST_RST: begin
        if (tmr_q == RST_LAST) begin
          state_d = ST_POLL;
          tmr_d   = '0;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      ST_POLL: begin
        if (init_i || (tmr_q == POLL_LAST)) begin
          state_d = ST_LOAD;
          stat_d  = init_i ? STAT_INIT_HI : STAT_INIT_TMO;
          acc_clr = 1'b1;
          pend_d  = 1'b0;
        end else begin
          tmr_d = tmr_q + TMR_W'(1);
        end
      end
      ST_LOAD: begin
        if (ack) begin
          if (is_rst_op) begin
            state_d = ST_RST;
            tmr_d   = '0;
            mode_d  = (op == OP_RST_FLASH) ? MODE_FLASH : MODE_HOST;
          end else begin
            state_d = ST_FIN;
          end
        end else if (pend_q && pul_done) begin
          state_d = ST_FIN;
          pend_d  = 1'b0;
        end else if (chunk_short) begin
          pend_d = 1'b1;
        end
      end
      ST_FIN: begin
        stat_d  = stat_q + (init_i ? STAT_FIN_HI : STAT_FIN_LO);
        state_d = ST_FLUSH;
        pul_d   = '0;
      end
      ST_FLUSH: begin
        if (pul_done) begin
          if (pul_q == FLUSH_LAST) begin
            state_d = ST_TAIL;
            pul_d   = '0;
          end else begin
            pul_d = pul_q + PUL_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (pul_done) begin
          if (pul_q == TAIL_LAST) begin
            state_d = ST_SAMPLE;
            pul_d   = '0;
          end else begin
            pul_d = pul_q + PUL_W'(1);
          end
        end
      end
      ST_SAMPLE: begin
        unconf_d = !done_i;
        if (done_i) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RST;
          tmr_d   = '0;
          mode_d  = MODE_HOST;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      pul_q    <= '0;
      mode_q   <= MODE_HOST;
      stat_q   <= '0;
      unconf_q <= 1'b1;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      tmr_q    <= tmr_d;
      pul_q    <= pul_d;
      mode_q   <= mode_d;
      stat_q   <= stat_d;
      unconf_q <= unconf_d;
      pend_q   <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (byte_acc) begin
      data_q <= s_data_i;
    end
  end

  // pin decode
  assign out_en_o     = (state_q != ST_IDLE) && (state_q != ST_SAMPLE);
  assign fpga_rst_n_o = (state_q != ST_RST);
  assign cs_n_o       = !out_en_o || (state_q == ST_RST) || (state_q == ST_TAIL);
  assign rdwr_o       = !out_en_o;
  assign mode_o       = mode_q;
  assign cclk_o       = pul_cclk;
  assign data_o       = data_q;
  assign cmd_ack_o    = ack;
  assign status_o     = stat_q;
  assign unconf_o     = unconf_q;
  assign loading_o    = (state_q == ST_LOAD);
  assign busy_o       = (state_q != ST_IDLE) && (state_q != ST_LOAD);

  // reset-length observer for the assertion below
  logic [RST_W:0] chk_low_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low_q <= '0;
    end else if (!fpga_rst_n_o) begin
      chk_low_q <= chk_low_q + (RST_W+1)'(1);
    end else begin
      chk_low_q <= '0;
    end
  end

  assert_rst_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fpga_rst_n_o) |-> (chk_low_q == (RST_W+1)'(RST_TICKS)));

  assert_load_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loading_o) |-> (byte_cnt_o == '0) && (checksum_o == 8'd0));

  assert_data_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(data_o));

  assert_ready_low_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_o |-> !s_ready_o);

  assert_checksum_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |=> (checksum_o == ($past(checksum_o) + $past(s_data_i))));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_acc |=> (byte_cnt_o == ($past(byte_cnt_o) + CNT_W'(1))));

  assert_release_after_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en_o) |-> $past(cs_n_o));

  assert_unconf_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unconf_o) |-> !fpga_rst_n_o);

endmodule

// File: tb/fpga_pcfg_master_tb.sv
module fpga_pcfg_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int RST_T      = 8;
  localparam int POLL_T     = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_req = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_ack;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = 8'd0;
  logic        s_last = 1'b0;
  logic        s_ready;
  logic        fpga_rst_n, cs_n, rdwr, cclk, out_en;
  logic [1:0]  mode;
  logic [7:0]  data, status, checksum;
  logic        init_in = 1'b0;
  logic        done_in = 1'b0;
  logic        unconf, busy, loading;
  logic [31:0] byte_cnt;

  fpga_pcfg_master #(
    .RST_TICKS (RST_T),
    .POLL_MAX  (POLL_T)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_req_i    (cmd_req),
    .cmd_op_i     (cmd_op),
    .cmd_ack_o    (cmd_ack),
    .s_valid_i    (s_valid),
    .s_data_i     (s_data),
    .s_last_i     (s_last),
    .s_ready_o    (s_ready),
    .fpga_rst_n_o (fpga_rst_n),
    .mode_o       (mode),
    .cs_n_o       (cs_n),
    .rdwr_o       (rdwr),
    .cclk_o       (cclk),
    .data_o       (data),
    .out_en_o     (out_en),
    .init_i       (init_in),
    .done_i       (done_in),
    .status_o     (status),
    .unconf_o     (unconf),
    .byte_cnt_o   (byte_cnt),
    .checksum_o   (checksum),
    .busy_o       (busy),
    .loading_o    (loading)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // monitor state, sampled at falling edges
  int         rst_low = 0, lo_rises = 0, hi_rises = 0;
  int         data_err = 0, setup_err = 0, rdy_err = 0, rst_pin_err = 0;
  logic [1:0] mode_seen = 2'd0;
  logic       cclk_prev = 1'b0;
  logic [7:0] data_prev = 8'd0;
  logic [7:0] exp_mem [0:511];
  int         n_exp = 0, base_lo = 0;
  int         exp_sum = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fpga_rst_n) begin
        rst_low++;
        mode_seen = mode;
        if (cs_n !== 1'b1 || rdwr !== 1'b0 || out_en !== 1'b1) rst_pin_err++;
      end
      if (cclk && s_ready) rdy_err++;
      if (cclk && !cclk_prev) begin
        if (data !== data_prev) setup_err++;
        if (!cs_n) begin
          if ((lo_rises - base_lo) < n_exp && data !== exp_mem[lo_rises - base_lo]) data_err++;
          lo_rises++;
        end else begin
          hi_rises++;
        end
      end
    end
    cclk_prev = cclk;
    data_prev = data;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  task automatic scen_start();
    base_lo = lo_rises;
    n_exp   = 0;
    exp_sum = 0;
  endtask

  task automatic cmd(input logic [1:0] op);
    @(negedge clk);
    cmd_req = 1'b1;
    cmd_op  = op;
    #1;
    while (!cmd_ack) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_req = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic l);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = b;
    s_last  = l;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    exp_mem[n_exp] = b;
    n_exp++;
    exp_sum += b;
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_load();
    do @(negedge clk); while (!loading);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || loading);
  endtask

  task automatic try_ignored(input logic [1:0] op, input string req);
    int acks;
    int rl;
    acks = 0;
    rl   = rst_low;
    @(negedge clk);
    cmd_req = 1'b1;
    cmd_op  = op;
    for (int i = 0; i < 6; i++) begin
      #1;
      if (cmd_ack) acks++;
      @(negedge clk);
    end
    cmd_req = 1'b0;
    chk(req, "ignored command ack count", acks, 0);
    chk(req, "ignored command state busy/loading/out_en", {busy, loading, out_en}, 0);
    chk(req, "ignored command reset cycles", rst_low - rl, 0);
  endtask

  initial begin
    int rl0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: state after reset
    chk("R11", "out_en after reset", out_en, 0);
    chk("R11", "unconf after reset", unconf, 1);
    chk("R11", "status after reset", status, 0);
    chk("R11", "byte count after reset", byte_cnt, 0);
    chk("R11", "s_ready after reset", s_ready, 0);

    // R10: codes 3 and finish are refused in idle
    try_ignored(2'd3, "R10");
    try_ignored(2'd2, "R10");

    // host load, INIT_B already high, DONE high
    init_in = 1'b1;
    done_in = 1'b1;
    rl0 = rst_low;
    cmd(2'd0);
    scen_start();
    wait_load();
    chk("R1", "reset low cycles host", rst_low - rl0, RST_T);
    chk("R1", "mode during host reset", mode_seen, 2);
    chk("R1", "pin errors during reset", rst_pin_err, 0);
    chk("R2", "status after poll with init high", status, 200);
    chk("R2", "count cleared", byte_cnt, 0);
    for (int i = 0; i < 64; i++) send_byte(8'((i * 37 + 5) & 255), i == 63);
    repeat (5) @(negedge clk);
    chk("R6", "full chunk keeps loading", loading, 1);
    for (int i = 0; i < 64; i++) send_byte(8'((i * 11 + 200) & 255), i == 63);
    for (int i = 0; i < 10; i++) send_byte(8'((255 - i * 3) & 255), i == 9);
    wait_idle();
    chk("R6", "short chunk ended load", loading, 0);
    chk("R5", "byte count 138", byte_cnt, 138);
    chk("R4", "checksum", checksum, exp_sum % 256);
    chk("R7", "status 200+22", status, 222);
    chk("R8", "pulses with cs low", lo_rises - base_lo, 138 + 64);
    chk("R8", "pulses with cs high", hi_rises, 4);
    chk("R8", "outputs released", out_en, 0);
    chk("R3", "data mismatches on bus", data_err, 0);
    chk("R3", "data not stable before rise", setup_err, 0);
    chk("R3", "ready high during pulse", rdy_err, 0);
    chk("R9", "configured flag", unconf, 0);

    // flash variant, INIT_B timeout, explicit finish, DONE low -> restart
    init_in = 1'b0;
    done_in = 1'b0;
    rl0 = rst_low;
    cmd(2'd1);
    scen_start();
    wait_load();
    chk("R1", "mode during flash reset", mode_seen, 3);
    chk("R2", "status after poll timeout", status, 100);
    for (int i = 0; i < 5; i++) send_byte(8'(i + 1), 1'b0);
    chk("R10", "still loading before finish", loading, 1);
    cmd(2'd2);
    while (!unconf) @(negedge clk);
    chk("R7", "status 100+11", status, 111);
    chk("R9", "restart drives reset", fpga_rst_n, 0);
    chk("R5", "count at finish", byte_cnt, 5);
    init_in = 1'b1;
    wait_load();
    chk("R9", "two reset phases", rst_low - rl0, 2 * RST_T);
    chk("R9", "restart uses host mode", mode_seen, 2);
    chk("R2", "status after re-poll", status, 200);
    chk("R2", "count cleared again", byte_cnt, 0);

    // checksum sweep over all byte values, then a 63-byte chunk
    done_in = 1'b1;
    scen_start();
    for (int i = 0; i < 256; i++) send_byte(8'(i), (i % 64) == 63);
    repeat (5) @(negedge clk);
    chk("R6", "four full chunks keep loading", loading, 1);
    for (int i = 0; i < 63; i++) send_byte(8'hFF, i == 62);
    wait_idle();
    chk("R5", "byte count 319", byte_cnt, 319);
    chk("R4", "checksum wrap sweep", checksum, exp_sum % 256);
    chk("R6", "63-byte chunk ended load", loading, 0);
    chk("R8", "sweep pulses with cs low", lo_rises - base_lo, 319 + 64);
    chk("R3", "sweep data mismatches", data_err, 0);
    chk("R9", "sweep configured", unconf, 0);

    // empty load ended by command
    rl0 = hi_rises;
    cmd(2'd0);
    wait_load();
    scen_start();
    cmd(2'd2);
    wait_idle();
    chk("R8", "empty load flush pulses", lo_rises - base_lo, 64);
    chk("R8", "empty load tail pulses", hi_rises - rl0, 4);
    chk("R5", "empty load count", byte_cnt, 0);
    chk("R7", "empty load status", status, 222);
    chk("R3", "final setup errors", setup_err, 0);

    finish_run();
  end

endmodule